// File: doc/BRIEF.md
# Pin Bank with Atomic Set/Clear Output Control

This block is one bank of general-purpose pins, up to 32 wide. It holds an output latch, a per-pin output-enable (direction) register, a sampled copy of the pin levels, and a 2-bit alternate-function code for every pin. Software reaches all of it through a plain single-cycle register bus made of a word address, a write enable, write data and combinational read data. The bus has no valid/ready handshake: every access completes in the cycle it is presented and the block never applies back-pressure.

Output bits are never written directly. One register turns on every latch bit written as 1, and another turns off every latch bit written as 1, so each caller can change its own pins without a read-modify-write. The latch keeps its value while a pin is an input. When the direction is later flipped, the pin drives the preset level straight away. A parameter shrinks the bank for a partial last bank. Pins above the count have no storage, read as 0 and ignore writes.

Top module: `gpio_setclr_bank`

## Requirements
- R1: A write to word address 2 (SET) makes every output-latch bit whose write-data bit is 1 equal to 1 on `pad_out`, and leaves the bits written as 0 unchanged.
- R2: A write to word address 3 (CLR) makes every output-latch bit whose write-data bit is 1 equal to 0 on `pad_out`, and leaves the bits written as 0 unchanged.
- R3: Word address 1 (DIR) is read/write. Bit value 1 makes the pin an output (`pad_oe` high) and 0 makes it an input. It reads back as written.
- R4: A read of word address 0 (LEVEL) returns `pin_in` as sampled at the most recent clock edge, for input and output pins alike.
- R5: The alternate-function code of pin p sits in bits [2*(p mod 16)+1 : 2*(p mod 16)] of word address 4 (FUNC_LO, pins 0-15) or word address 5 (FUNC_HI, pins 16-31). It reads back there and drives `func_sel[2p+1:2p]`.
- R6: The output latch can be written while the pin is an input. In the first cycle that `pad_oe` is high, `pad_out` already shows the preset level.
- R7: With NUM_PINS below 32, bits of pins at or above NUM_PINS read as 0 in every register, and writing them has no effect.
- R8: Reads of SET and CLR return 0.
- R9: After reset all pins are inputs, the output latch is 0, and every function code is 0.
- R10: SET, CLR, DIR and FUNC writes take effect at the next rising clock edge, and `pad_out` changes only after a SET or CLR write.
- R11: Word addresses 6 and 7 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Levels seen at the pads |
| pad_out | output | NUM_PINS | Output latch, driven to the pads |
| pad_oe | output | NUM_PINS | Per-pin output enable (direction) |
| func_sel | output | 2*NUM_PINS | Packed 2-bit alternate-function code per pin |

## Verification
The hardest case to reach from the ports is the preset-then-enable order. The bench puts a pin's latch to 1 while the pin is still an input, confirms that `pad_oe` stays low, then writes the direction and checks `pad_out` and `pad_oe` together in the first cycle after that edge. The partial-bank case is reached by building the instance with 21 pins and writing all-ones words to every register, so that the masked upper bits and the short FUNC_HI readback can be seen. A behavioural model updated on every clock edge is compared with every output on every cycle while writes and changing pin patterns are interleaved.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W          = 32;
  localparam int ADDR_W          = 3;
  localparam int FIELD_W         = 2;
  localparam int PINS_PER_FUNC_W = DATA_W / FIELD_W;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL   = 3'd0,
    REG_DIR     = 3'd1,
    REG_SET     = 3'd2,
    REG_CLR     = 3'd3,
    REG_FUNC_LO = 3'd4,
    REG_FUNC_HI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic dir_we;
    logic set_we;
    logic clr_we;
    logic func_lo_we;
    logic func_hi_we;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_bank_pkg::*;
(
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobe_t        strobe
);
  always_comb begin
    strobe = '0;
    if (we) begin
      case (addr)
        REG_DIR:     strobe.dir_we     = 1'b1;
        REG_SET:     strobe.set_we     = 1'b1;
        REG_CLR:     strobe.clr_we     = 1'b1;
        REG_FUNC_LO: strobe.func_lo_we = 1'b1;
        REG_FUNC_HI: strobe.func_hi_we = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wr_strobe_t          strobe,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] dir_q
);
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] out_d;

  assign wbits = wdata[NUM_PINS-1:0];

  always_comb begin
    out_d = out_q;
    if (strobe.set_we)      out_d = out_q | wbits;
    else if (strobe.clr_we) out_d = out_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_d;
      if (strobe.dir_we) dir_q <= wbits;
    end
  end
endmodule

// File: rtl/gpio_func_regs.sv
module gpio_func_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wr_strobe_t                  strobe,
  input  logic [DATA_W-1:0]           wdata,
  output logic [FIELD_W*NUM_PINS-1:0] func_sel,
  output logic [DATA_W-1:0]           lo_word,
  output logic [DATA_W-1:0]           hi_word
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int  POS    = (p % PINS_PER_FUNC_W) * FIELD_W;
    localparam bit  IN_HI  = (p >= PINS_PER_FUNC_W);
    logic [FIELD_W-1:0] fld_q;
    logic               wr;

    assign wr = IN_HI ? strobe.func_hi_we : strobe.func_lo_we;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  fld_q <= '0;
      else if (wr) fld_q <= wdata[POS +: FIELD_W];
    end

    assign func_sel[p*FIELD_W +: FIELD_W] = fld_q;
  end

  always_comb begin
    lo_word = '0;
    hi_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (p < PINS_PER_FUNC_W)
        lo_word[(p % PINS_PER_FUNC_W)*FIELD_W +: FIELD_W] = func_sel[p*FIELD_W +: FIELD_W];
      else
        hi_word[(p % PINS_PER_FUNC_W)*FIELD_W +: FIELD_W] = func_sel[p*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] level_q,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [DATA_W-1:0]   func_lo,
  input  logic [DATA_W-1:0]   func_hi,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] level_w;
  logic [DATA_W-1:0] dir_w;

  always_comb begin
    level_w = '0;
    dir_w   = '0;
    level_w[NUM_PINS-1:0] = level_q;
    dir_w[NUM_PINS-1:0]   = dir_q;
  end

  always_comb begin
    case (addr)
      REG_LEVEL:   rdata = level_w;
      REG_DIR:     rdata = dir_w;
      REG_FUNC_LO: rdata = func_lo;
      REG_FUNC_HI: rdata = func_hi;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe,
  output logic [FIELD_W*NUM_PINS-1:0] func_sel
);
  wr_strobe_t          strobe;
  logic [NUM_PINS-1:0] level_q;
  logic [DATA_W-1:0]   func_lo;
  logic [DATA_W-1:0]   func_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= pin_in;
  end

  gpio_wr_decode u_dec (
    .we     (bus_we),
    .addr   (bus_addr),
    .strobe (strobe)
  );

  gpio_pin_ctrl #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wdata  (bus_wdata),
    .out_q  (pad_out),
    .dir_q  (pad_oe)
  );

  gpio_func_regs #(.NUM_PINS(NUM_PINS)) u_func (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wdata    (bus_wdata),
    .func_sel (func_sel),
    .lo_word  (func_lo),
    .hi_word  (func_hi)
  );

  gpio_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
    .addr    (bus_addr),
    .level_q (level_q),
    .dir_q   (pad_oe),
    .func_lo (func_lo),
    .func_hi (func_hi),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [NUM_PINS-1:0]         pad_out,
  input logic [NUM_PINS-1:0]         pad_oe,
  input logic [FIELD_W*NUM_PINS-1:0] func_sel
);
  assert_set_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_SET) |=>
      ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  assert_set_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_SET) |=>
      (((pad_out ^ $past(pad_out)) & ~$past(bus_wdata[NUM_PINS-1:0])) == '0));

  assert_clr_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_CLR) |=>
      ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == '0));

  assert_clr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_CLR) |=>
      (((pad_out ^ $past(pad_out)) & ~$past(bus_wdata[NUM_PINS-1:0])) == '0));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_DIR) |=> (pad_oe == $past(bus_wdata[NUM_PINS-1:0])));

  assert_func_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_FUNC_LO) |=> (func_sel[1:0] == $past(bus_wdata[1:0])));

  assert_setclr_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_SET || bus_addr == REG_CLR) |-> (bus_rdata == '0));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == REG_SET || bus_addr == REG_CLR)) |=> $stable(pad_out));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > REG_FUNC_HI) |-> (bus_rdata == '0));

  if (NUM_PINS < DATA_W) begin : g_partial
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_LEVEL || bus_addr == REG_DIR) |->
        (bus_rdata[DATA_W-1:NUM_PINS] == '0));
  end
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .func_sel  (func_sel)
);

// File: tb/gpio_setclr_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_setclr_bank_tb_top;
  localparam int NP = 21;
  localparam logic [31:0] MASK = 32'h001F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [2*NP-1:0] func_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_setclr_bank #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .func_sel(func_sel)
  );

  // behavioural reference
  logic [31:0] m_out = '0, m_dir = '0, m_level = '0;
  logic [1:0]  m_func [32];
  initial for (int i = 0; i < 32; i++) m_func[i] = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_level = 0;
      for (int i = 0; i < 32; i++) m_func[i] = 0;
    end else begin
      m_level = 32'(pin_in) & MASK;
      if (bus_we) begin
        case (bus_addr)
          3'd1: m_dir = bus_wdata & MASK;
          3'd2: m_out = (m_out | bus_wdata) & MASK;
          3'd3: m_out = m_out & ~bus_wdata & MASK;
          3'd4: for (int i = 0; i < 16; i++) if (i < NP) m_func[i] = bus_wdata[2*i +: 2];
          3'd5: for (int i = 16; i < 32; i++) if (i < NP) m_func[i] = bus_wdata[2*(i-16) +: 2];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] w;
    w = 0;
    case (a)
      3'd0: w = m_level;
      3'd1: w = m_dir;
      3'd4: for (int i = 0; i < 16; i++) if (i < NP) w[2*i +: 2] = m_func[i];
      3'd5: for (int i = 16; i < 32; i++) if (i < NP) w[2*(i-16) +: 2] = m_func[i];
      default: w = 0;
    endcase
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [63:0] ef;
    ef = 0;
    for (int i = 0; i < NP; i++) ef[2*i +: 2] = m_func[i];
    chk("R10 model pad_out", 64'(pad_out), 64'(m_out));
    chk("R10 model pad_oe", 64'(pad_oe), 64'(m_dir));
    chk("R10 model func_sel", 64'(func_sel), ef);
    chk("R10 model rdata", 64'(bus_rdata), 64'(m_read(bus_addr)));
  endtask

  task automatic step(input logic [2:0] a, input logic we, input logic [31:0] d);
    @(negedge clk);
    compare_model();
    bus_addr = a; bus_we = we; bus_wdata = d;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    step(a, 1'b0, 32'h0);
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 pad_out reset", 64'(pad_out), 0);
    chk("R9 pad_oe reset", 64'(pad_oe), 0);
    chk("R9 func_sel reset", 64'(func_sel), 0);
    rst_n = 1'b1;
    rd(3'd1, v); chk("R9 DIR read reset", 64'(v), 0);

    // R3: direction write and readback
    step(3'd1, 1'b1, 32'h000F_0F0F);
    rd(3'd1, v); chk("R3 DIR readback", 64'(v), 64'h000F_0F0F);
    chk("R3 pad_oe", 64'(pad_oe), 64'h000F_0F0F);

    // R1 / R10: set bits, change visible only after the edge
    step(3'd2, 1'b1, 32'h000F_00FF);
    chk("R10 pad_out before edge", 64'(pad_out), 0);
    step(3'd0, 1'b0, 0);
    chk("R1 set", 64'(pad_out), 64'h000F_00FF);
    step(3'd2, 1'b1, 32'h0000_0300);
    step(3'd0, 1'b0, 0);
    chk("R1 set keeps others", 64'(pad_out), 64'h000F_03FF);

    // R2: clear
    step(3'd3, 1'b1, 32'h0001_000F);
    step(3'd0, 1'b0, 0);
    chk("R2 clear", 64'(pad_out), 64'h000E_03F0);

    // R6: preset pin 20 while input, then enable
    step(3'd2, 1'b1, 32'h0010_0000);
    step(3'd0, 1'b0, 0);
    chk("R6 preset while input oe", 64'(pad_oe[20]), 0);
    chk("R6 preset latched", 64'(pad_out[20]), 1);
    step(3'd1, 1'b1, 32'h001F_0F0F);
    step(3'd0, 1'b0, 0);
    chk("R6 first driven cycle oe", 64'(pad_oe[20]), 1);
    chk("R6 first driven cycle level", 64'(pad_out[20]), 1);

    // R4: level register on mixed direction pins
    pin_in = 21'h15_5555;
    step(3'd0, 1'b0, 0);
    rd(3'd0, v); chk("R4 level pattern a", 64'(v), 64'h0015_5555);
    pin_in = 21'h0A_AAAA;
    step(3'd0, 1'b0, 0);
    rd(3'd0, v); chk("R4 level pattern b", 64'(v), 64'h000A_AAAA);

    // R5: function fields
    step(3'd4, 1'b1, 32'hE4E4_E4E4);
    step(3'd0, 1'b0, 0);
    chk("R5 func_sel low pins", 64'(func_sel[7:0]), 64'hE4);
    rd(3'd4, v); chk("R5 FUNC_LO readback", 64'(v), 64'hE4E4_E4E4);
    step(3'd5, 1'b1, 32'hFFFF_FFFF);
    step(3'd0, 1'b0, 0);
    chk("R5 func_sel high pins", 64'(func_sel[41:32]), 64'h3FF);

    // R7: partial bank
    rd(3'd5, v); chk("R7 FUNC_HI short readback", 64'(v), 64'h0000_03FF);
    step(3'd1, 1'b1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R7 DIR upper bits", 64'(v), 64'(MASK));
    pin_in = '1;
    step(3'd0, 1'b0, 0);
    rd(3'd0, v); chk("R7 LEVEL upper bits", 64'(v), 64'(MASK));

    // R8: set/clear read as zero
    rd(3'd2, v); chk("R8 SET reads 0", 64'(v), 0);
    rd(3'd3, v); chk("R8 CLR reads 0", 64'(v), 0);

    // R11: unmapped addresses
    step(3'd6, 1'b1, 32'hFFFF_FFFF);
    step(3'd7, 1'b1, 32'h0000_0000);
    rd(3'd6, v); chk("R11 addr 6 reads 0", 64'(v), 0);
    rd(3'd7, v); chk("R11 addr 7 reads 0", 64'(v), 0);
    chk("R11 no effect on pad_out", 64'(pad_out), 64'h001E_03F0);
    chk("R11 no effect on pad_oe", 64'(pad_oe), 64'(MASK));

    // mixed traffic checked against the model every cycle
    for (int k = 0; k < 60; k++) begin
      pin_in = NP'(k * 32'h0003_3A1D);
      step(3'(k % 8), (k % 3) != 0, k * 32'h1357_9BDF);
    end
    step(3'd0, 1'b0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule